// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block decides, every clock cycle, which of eight hardware thread contexts may place an instruction into a shared four-stage pipeline. Each cycle it drives the chosen context number together with a valid strobe. Downstream fetch logic uses that strobe and number to pick the program counter and register bank for the new pipeline slot.

A context is eligible when three things hold. Its run-enable input is high. Its internal ready flag is set. Its previous instruction has left the pipeline. The ready flag is cleared by a pause request, which a context sends when it starts waiting on an event. A wake event for that context sets the flag again. A context is never issued twice inside one pipeline depth. So when fewer than four contexts are runnable, the pipeline takes empty slots rather than letting a single context run faster. When four or more contexts are runnable, every slot is filled and the slots are shared evenly among them in rotating order.

Top module: `barrel_sched`

## Requirements
- R1: The reset is synchronous and active low. After reset only context 0 has its ready flag set, all spacing counters are zero, and the rotation starts at context 0. With every run-enable high and no wake events, context 0 issues in cycles 0 and 4 after reset, and cycles 1 to 3 are empty.
- R2: A context is issued only if its run-enable bit is high, its ready flag is set, and its spacing counter is zero.
- R3: After a context issues in cycle t, it is not issued again before cycle t+4 (one pipeline depth).
- R4: Among the eligible contexts, the one issued is the first found when searching upward, with wrap-around, starting at the context after the last one that issued.
- R5: If no context is eligible, issue_valid is low and issue_tid reads 0. If any context is eligible, issue_valid is high.
- R6: A pause request without a wake for context i clears its ready flag from the next cycle on. A paused context takes no issue slots.
- R7: A wake event for context i sets its ready flag from the next cycle on.
- R8: If a pause request and a wake event reach the same context in the same cycle, the context stays ready.
- R9: With k of 4 or more contexts runnable and ready, every cycle issues, and each context issues exactly once in every k consecutive cycles of steady state.
- R10: With k of 1 to 3 contexts runnable and ready, each context issues exactly once in every 4 cycles of steady state, and 4-k of every 4 cycles are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 8 | Run-enable level, one bit per context |
| pause_req | input | 8 | One-cycle pause request, one bit per context |
| wake_evt | input | 8 | One-cycle wake event, one bit per context |
| issue_valid | output | 1 | High when a context issues this cycle |
| issue_tid | output | 3 | Context issued this cycle (0 when not valid) |

## Verification
Each kind of bad internal state shows up at the ports almost at once. A spacing counter that is stuck or reloaded wrongly puts one context number into a four-cycle window twice, or removes it for longer than one pipeline depth, within about five cycles. A bad rotation pointer changes the order of context numbers in the very next cycle. A lost or stray ready flag adds a context to the rotation, or takes one out, in the cycle after the pause or wake that caused it. The bench compares every cycle against an arithmetic model. It also counts issues per context over whole rotation windows for every one of the 256 run-enable masks.

// File: rtl/sched_pkg.sv
// Package: shared defaults and helper for the barrel thread scheduler.
// Assumes the pipeline depth is at least 2.
package sched_pkg;
    localparam int DEF_THREADS    = 8;
    localparam int DEF_PIPE_DEPTH = 4;

    // Width of a counter that holds values 0 .. depth-1
    function automatic int cd_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction
endpackage

// File: rtl/sched_ready.sv
// Module: sched_ready
// Keeps one ready flag per context. A pause clears the flag and a wake sets it.
// When both arrive in the same cycle, the wake wins.
// Assumes pause and wake are single-cycle pulses in the clk domain.
module sched_ready #(
    parameter int N = sched_pkg::DEF_THREADS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pause_req,
    input  logic [N-1:0] wake_evt,
    output logic [N-1:0] ready
);
    localparam logic [N-1:0] RESET_MASK = N'(1);

    logic [N-1:0] ready_q;

    // Ready flags: reset to context 0 only, wake takes priority over pause
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= RESET_MASK;
        else        ready_q <= (ready_q & ~pause_req) | wake_evt;
    end

    assign ready = ready_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_wake_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_evt[i] && pause_req[i]) |=> ready[i]);
        assert_wake_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wake_evt[i] |=> ready[i]);
        assert_pause_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pause_req[i] && !wake_evt[i]) |=> !ready[i]);
    end
endmodule

// File: rtl/sched_cooldown.sv
// Module: sched_cooldown
// Gives each context a spacing counter that is loaded with DEPTH-1 when the
// context issues and counts down to zero. A context may issue only at zero.
// Assumes grant is one-hot or zero.
module sched_cooldown #(
    parameter int N     = sched_pkg::DEF_THREADS,
    parameter int DEPTH = sched_pkg::DEF_PIPE_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant,
    output logic [N-1:0] cool
);
    localparam int CW = sched_pkg::cd_bits(DEPTH);
    localparam logic [CW-1:0] RELOAD = CW'(DEPTH - 1);

    for (genvar i = 0; i < N; i++) begin : g_cd
        logic [CW-1:0] cnt_q;

        // Spacing counter: reload on issue, otherwise count down to zero
        always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (grant[i])      cnt_q <= RELOAD;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end

        assign cool[i] = (cnt_q == '0);

        assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q != '0) |-> !grant[i]);
        assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> !cool[i]);
    end
endmodule

// File: rtl/sched_rr_pick.sv
// Module: sched_rr_pick
// Round-robin arbiter. Searches upward from the context after the last one
// that issued and grants the first eligible context. Holds the rotation pointer.
// Assumes N is at least 2.
module sched_rr_pick #(
    parameter int N = sched_pkg::DEF_THREADS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         elig,
    output logic [N-1:0]         grant,
    output logic                 valid,
    output logic [$clog2(N)-1:0] tid
);
    localparam int TW = $clog2(N);
    localparam logic [TW:0]   NW      = (TW+1)'(N);
    localparam logic [TW-1:0] LAST_RS = TW'(N - 1);

    logic [TW-1:0] last_q;
    logic [TW-1:0] cand [N];

    // Candidate order: last_q+1, last_q+2, ... wrapped modulo N
    for (genvar k = 0; k < N; k++) begin : g_cand
        logic [TW:0] sum;
        assign sum     = {1'b0, last_q} + (TW+1)'(k + 1);
        assign cand[k] = (sum >= NW) ? TW'(sum - NW) : sum[TW-1:0];
    end

    // First eligible candidate in rotation order
    always_comb begin
        valid = 1'b0;
        tid   = '0;
        for (int k = 0; k < N; k++) begin
            if (!valid && elig[cand[k]]) begin
                valid = 1'b1;
                tid   = cand[k];
            end
        end
    end

    // One-hot grant vector from the chosen index
    always_comb begin
        grant = '0;
        if (valid) grant[tid] = 1'b1;
    end

    // Rotation pointer: remember the last context that issued
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= LAST_RS;
        else if (valid) last_q <= tid;
    end

    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_elig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig) == '0);
    assert_no_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> valid);
    assert_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(elig) > 1 && valid) |=> !(valid && tid == $past(tid)));
endmodule

// File: rtl/barrel_sched.sv
// Module: barrel_sched (top)
// Barrel thread issue scheduler. Combines the run-enable inputs, the ready
// flags and the spacing counters into an eligibility mask, then picks one
// context per cycle in round-robin order.
// Assumes the outputs feed a pipeline DEPTH stages deep. The outputs are
// combinational from state and run_en.
module barrel_sched #(
    parameter int N     = sched_pkg::DEF_THREADS,
    parameter int DEPTH = sched_pkg::DEF_PIPE_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         run_en,
    input  logic [N-1:0]         pause_req,
    input  logic [N-1:0]         wake_evt,
    output logic                 issue_valid,
    output logic [$clog2(N)-1:0] issue_tid
);
    logic [N-1:0] ready;
    logic [N-1:0] cool;
    logic [N-1:0] elig;
    logic [N-1:0] grant;

    sched_ready #(.N(N)) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .pause_req (pause_req),
        .wake_evt  (wake_evt),
        .ready     (ready)
    );

    sched_cooldown #(.N(N), .DEPTH(DEPTH)) u_cool (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (grant),
        .cool  (cool)
    );

    // Eligibility: enabled, ready and out of the pipeline
    assign elig = run_en & ready & cool;

    sched_rr_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .grant (grant),
        .valid (issue_valid),
        .tid   (issue_tid)
    );

    assert_run_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> run_en[issue_tid]);
    assert_idle_tid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_tid == '0));
endmodule

// File: tb/barrel_sched_bench.sv
module barrel_sched_bench;
    localparam int N = 8;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] run_en = '0;
    logic [7:0] pause_req = '0;
    logic [7:0] wake_evt = '0;
    logic       issue_valid;
    logic [2:0] issue_tid;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    // Model state
    logic [7:0] ready_m;
    int         cd_m [8];
    int         last_m;
    int         cnt_t [8];
    int         cnt_v;
    string      tag = "R4";

    always #10 clk = ~clk;

    barrel_sched u_barrel_sched (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pause_req(pause_req),
        .wake_evt(wake_evt), .issue_valid(issue_valid), .issue_tid(issue_tid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        ready_m = 8'b0000_0001;
        for (int i = 0; i < N; i++) cd_m[i] = 0;
        last_m = N - 1;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < N; i++) cnt_t[i] = 0;
        cnt_v = 0;
    endtask

    // One cycle: compare at the falling edge, then advance the model at the rising edge
    task automatic step();
        bit ev;
        int et;
        @(negedge clk);
        ev = 1'b0;
        et = 0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (last_m + k) % N;
            if (!ev && run_en[idx] && ready_m[idx] && cd_m[idx] == 0) begin
                ev = 1'b1;
                et = idx;
            end
        end
        check(issue_valid == ev, {tag, " R5 valid"}, int'(issue_valid), int'(ev));
        check(int'(issue_tid) == et, {tag, " R2 tid"}, int'(issue_tid), et);
        if (issue_valid) begin
            cnt_t[issue_tid]++;
            cnt_v++;
        end
        @(posedge clk);
        cyc++;
        for (int i = 0; i < N; i++) begin
            if (cd_m[i] > 0) cd_m[i]--;
            if (ev && et == i) cd_m[i] = D - 1;
        end
        ready_m = (ready_m & ~pause_req) | wake_evt;
        if (ev) last_m = et;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pause_req = '0;
        wake_evt = '0;
        repeat (2) @(posedge clk);
        model_reset();
        #1 rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;

        // R1: reset state, only context 0 ready, issue at cycles 0 and 4
        run_en = 8'hFF;
        do_reset();
        clear_counts();
        tag = "R1";
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            check(issue_valid == ((c % 4) == 0), "R1 reset issue pattern", int'(issue_valid), int'((c % 4) == 0));
            check(issue_tid == 3'd0, "R1 reset tid", int'(issue_tid), 0);
            @(posedge clk);
            #1;
        end

        // R9/R10: sweep all run-enable masks
        for (int m = 0; m < 256; m++) begin
            int k, win, expv, expt;
            run_en = '0;
            do_reset();
            tag = "R4";
            wake_evt = 8'hFF;
            step();
            wake_evt = '0;
            run_en = 8'(m);
            repeat (8) step();
            k = $countones(8'(m));
            win = (k >= 4) ? 4 * k : 16;
            expt = 4;
            expv = (k >= 4) ? win : 4 * k;
            clear_counts();
            repeat (win) step();
            if (k >= 4) check(cnt_v == expv, "R9 slots filled", cnt_v, expv);
            else        check(cnt_v == expv, "R10 bubbles", cnt_v, expv);
            for (int i = 0; i < N; i++) begin
                int e;
                e = m[i] ? expt : 0;
                if (k >= 4) check(cnt_t[i] == e, "R9 equal share", cnt_t[i], e);
                else        check(cnt_t[i] == e, "R10 capped rate", cnt_t[i], e);
            end
        end

        // R6/R7/R8: directed pause and wake on context 3 with contexts 0..3 enabled
        run_en = '0;
        do_reset();
        tag = "R6";
        wake_evt = 8'hFF;
        step();
        wake_evt = '0;
        run_en = 8'h0F;
        repeat (8) step();
        pause_req = 8'h08;
        wake_evt = 8'h08;
        step();
        pause_req = '0;
        wake_evt = '0;
        clear_counts();
        repeat (16) step();
        check(cnt_t[3] == 4, "R8 wake wins over pause", cnt_t[3], 4);
        pause_req = 8'h08;
        step();
        pause_req = '0;
        clear_counts();
        repeat (16) step();
        check(cnt_t[3] == 0, "R6 paused context idle", cnt_t[3], 0);
        check(cnt_v == 12, "R6 paused slots become bubbles", cnt_v, 12);
        tag = "R7";
        wake_evt = 8'h08;
        step();
        wake_evt = '0;
        repeat (4) step();
        clear_counts();
        repeat (16) step();
        check(cnt_t[3] == 4, "R7 woken context rejoins", cnt_t[3], 4);

        // R2/R3/R6/R7: pseudo-random stress against the model
        run_en = '0;
        do_reset();
        tag = "R3";
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (c % 37 == 0) run_en = lfsr[7:0] | lfsr[15:8];
            pause_req = lfsr[7:0] & lfsr[15:8] & {lfsr[3:0], lfsr[7:4]};
            wake_evt  = ~lfsr[7:0] & lfsr[11:4] & {lfsr[9:2]};
            step();
        end
        pause_req = '0;
        wake_evt = '0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule